// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to eight interrupt request lines on behalf of an 8-bit processor and presents one interrupt output. Requests are captured in a pending register (edge or level sensed), filtered by a mask register and ranked by a fixed-priority resolver in which line 0 wins and line 7 loses. An in-service register records the levels the processor is handling, so a new request only interrupts when it outranks every level already in service.

The processor answers the interrupt with three acknowledge strobes. The block returns a CALL opcode, then the low byte of the handler address and then its high byte. The low byte combines programmed upper address bits with the level number, using a 4-byte or an 8-byte spacing between handlers. The in-service bit is cleared either automatically after the second strobe or by an end-of-interrupt command written by software.

A small register port (chip select, read, write, one address bit) carries the initialization sequence and the run-time commands. All strobes are single-cycle and active high, and they are taken in the cycle they are seen. The acknowledge byte and the read data are combinational in the strobe cycle. No pin holds anything back, so there is no back-pressure anywhere.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Among unmasked pending requests, the lowest line number has the highest priority. Line 0 beats every other line, and line 7 loses to every other line.
- R2: In edge mode, a pending bit is set only by a low-to-high change of its line, and the bit stays set only while the line stays high. A line that is already high when initialization starts is not taken. A line that is held high after its acknowledge does not request again.
- R3: The interrupt output is low until the initialization sequence has completed. The sequence is: the first word, the page word, a cascade word only when the first word has bit 1 = 0, and an options word only when the first word has bit 0 = 1.
- R4: When initialized, the interrupt output is high exactly when an unmasked pending request exists and its level number is lower than that of the highest-priority in-service level, or when nothing is in service.
- R5: Successive acknowledge strobes return 0xCD, then the handler low byte, then the handler high byte (the page word). The fourth strobe starts a new sequence.
- R6: On the first strobe, the winning level's in-service bit is set and its pending bit is cleared. If nothing is pending, the vector for level 7 is returned and the in-service register is unchanged.
- R7: The handler low byte is made from the level number L and the first word's bits 7..5 (B). With 4-byte spacing (first word bit 2 = 1), the byte is {B[2:0], L, 2'b00}. With 8-byte spacing (bit 2 = 0), the byte is {B[2:1], L, 3'b000}.
- R8: With automatic end-of-interrupt (options word bit 1 = 1), the in-service bit is cleared after the second strobe. Otherwise, it stays set through the third strobe.
- R9: The end-of-interrupt commands are writes with a0 = 0 and data bits 4 and 3 both 0. Data bits 7..5 = 001 clear the highest-priority in-service bit. Data bits 7..5 = 011 clear the in-service bit named by data bits 2..0.
- R10: A write with a0 = 0 and data bit 4 = 1 is the first initialization word. It does all of the following:
  - clears the mask, pending, in-service and edge state;
  - restarts the acknowledge sequence;
  - selects pending status for reads;
  - turns automatic end-of-interrupt off. It stays off when bit 0 = 0, because no options word follows.
- R11: After initialization, a write with a0 = 1 loads the mask, and a read with a0 = 1 returns it. A masked line still latches as pending but does not raise the interrupt.
- R12: A status-select write has a0 = 0, data bit 4 = 0, bit 3 = 1 and bit 1 = 1. With data bit 0 = 1, reads with a0 = 0 return the in-service register; with data bit 0 = 0, they return the pending register.
- R13: In level mode (first word bit 3 = 1), a high line is a request. It requests again after its acknowledge, and it stops requesting when the line goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Register port select |
| rd | input | 1 | Register read strobe |
| wr | input | 1 | Register write strobe |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd are high |
| irq | input | N_LVL | Request lines |
| int_out | output | 1 | Interrupt to the processor |
| ack_stb | input | 1 | Acknowledge strobe, one cycle per byte |
| ack_byte | output | 8 | Byte returned for the current acknowledge strobe |

## Verification
Two simultaneous requests (lines 2 and 5) show that the resolver picks the lower line number and that the pending register keeps the loser. A later request on line 0 shows nesting above an in-service level, and end-of-interrupt commands then release both levels in order. A request masked while it arrives tells latching apart from signalling. A line held high across initialization tells edge from level sensing. Re-initializing with each spacing and end-of-interrupt option separates the two low-byte layouts and the automatic and explicit release. An acknowledge with nothing pending checks the fallback vector.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam logic [7:0] CALL_OPCODE = 8'hCD;

  typedef enum logic [2:0] {
    CFG_RESET,
    CFG_PAGE,
    CFG_CASC,
    CFG_OPT,
    CFG_RUN
  } cfg_state_e;

  typedef struct packed {
    logic       level_mode;
    logic       four_byte;
    logic       auto_eoi;
    logic [2:0] base_hi;
    logic [7:0] page;
  } vec_cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_vec_pkg::*;
#(
  parameter int N_LVL = 8,
  localparam int LVL_W = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             wr,
  input  logic             a0,
  input  logic [7:0]       wdata,
  output vec_cfg_t         cfg_o,
  output logic [N_LVL-1:0] mask_o,
  output logic             read_isr_o,
  output logic             init_done_o,
  output logic             restart_o,
  output logic             eoi_any_o,
  output logic             eoi_spec_o,
  output logic [LVL_W-1:0] eoi_lvl_o
);
  cfg_state_e       state_q;
  vec_cfg_t         cfg_q;
  logic [N_LVL-1:0] mask_q;
  logic             read_isr_q;
  logic             single_q;
  logic             need_opt_q;

  logic wr_en, restart, ctl_wr, cmd_wr;

  assign wr_en   = cs & wr;
  assign restart = wr_en & ~a0 & wdata[4];
  assign ctl_wr  = wr_en & ~a0 & ~wdata[4] & (state_q == CFG_RUN);
  assign cmd_wr  = ctl_wr & ~wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CFG_RESET;
      cfg_q      <= '0;
      mask_q     <= '0;
      read_isr_q <= 1'b0;
      single_q   <= 1'b1;
      need_opt_q <= 1'b0;
    end else if (restart) begin
      state_q          <= CFG_PAGE;
      cfg_q.base_hi    <= wdata[7:5];
      cfg_q.level_mode <= wdata[3];
      cfg_q.four_byte  <= wdata[2];
      cfg_q.auto_eoi   <= 1'b0;
      single_q         <= wdata[1];
      need_opt_q       <= wdata[0];
      mask_q           <= '0;
      read_isr_q       <= 1'b0;
    end else if (wr_en && a0) begin
      case (state_q)
        CFG_PAGE: begin
          cfg_q.page <= wdata;
          if (!single_q)      state_q <= CFG_CASC;
          else if (need_opt_q) state_q <= CFG_OPT;
          else                state_q <= CFG_RUN;
        end
        CFG_CASC: state_q <= need_opt_q ? CFG_OPT : CFG_RUN;
        CFG_OPT: begin
          cfg_q.auto_eoi <= wdata[1];
          state_q        <= CFG_RUN;
        end
        CFG_RUN:  mask_q <= wdata[N_LVL-1:0];
        default:  ;
      endcase
    end else if (ctl_wr && wdata[3] && wdata[1]) begin
      read_isr_q <= wdata[0];
    end
  end

  assign cfg_o       = cfg_q;
  assign mask_o      = mask_q;
  assign read_isr_o  = read_isr_q;
  assign init_done_o = (state_q == CFG_RUN);
  assign restart_o   = restart;
  assign eoi_any_o   = cmd_wr & (wdata[7:5] == 3'b001);
  assign eoi_spec_o  = cmd_wr & (wdata[7:5] == 3'b011);
  assign eoi_lvl_o   = wdata[LVL_W-1:0];
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N_LVL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             level_mode_i,
  input  logic [N_LVL-1:0] irq_i,
  input  logic [N_LVL-1:0] take_i,
  output logic [N_LVL-1:0] irr_o
);
  for (genvar g = 0; g < N_LVL; g++) begin : g_line
    logic armed_q;
    logic irr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed_q <= 1'b0;
        irr_q   <= 1'b0;
      end else if (restart_i) begin
        armed_q <= 1'b0;
        irr_q   <= 1'b0;
      end else begin
        // a low line arms the edge detector; the rising edge consumes it
        if (!irq_i[g])    armed_q <= 1'b1;
        else if (armed_q) armed_q <= 1'b0;
        irr_q <= irq_i[g] & ~take_i[g] & (level_mode_i | irr_q | armed_q);
      end
    end

    assign irr_o[g] = irr_q;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_LVL = 8,
  localparam int LVL_W = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] vec_i,
  output logic             any_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [N_LVL-1:0] below;
  logic [N_LVL-1:0] grant;

  assign below[0] = 1'b0;
  for (genvar g = 1; g < N_LVL; g++) begin : g_chain
    assign below[g] = below[g-1] | vec_i[g-1];
  end
  assign grant = vec_i & ~below;

  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (grant[i]) lvl_o = lvl_o | LVL_W'(i);
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int N_LVL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic             a0,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [N_LVL-1:0] irq,
  output logic             int_out,
  input  logic             ack_stb,
  output logic [7:0]       ack_byte
);
  localparam int LVL_W = $clog2(N_LVL);

  vec_cfg_t         cfg;
  logic [N_LVL-1:0] mask, irr, pend, take;
  logic [N_LVL-1:0] isr_q, isr_d;
  logic             read_isr, init_done, restart;
  logic             eoi_any, eoi_spec;
  logic [LVL_W-1:0] eoi_lvl;
  logic             pend_any, isr_any;
  logic [LVL_W-1:0] pend_lvl, isr_lvl;
  logic [1:0]       step_q;
  logic [LVL_W-1:0] cur_lvl_q;
  logic             cur_real_q;
  logic             ack_go;
  logic [7:0]       low_byte;

  irq_cfg_regs #(.N_LVL(N_LVL)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .a0(a0), .wdata(wdata),
    .cfg_o(cfg), .mask_o(mask), .read_isr_o(read_isr), .init_done_o(init_done),
    .restart_o(restart), .eoi_any_o(eoi_any), .eoi_spec_o(eoi_spec),
    .eoi_lvl_o(eoi_lvl)
  );

  irq_req_latch #(.N_LVL(N_LVL)) req_i (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .level_mode_i(cfg.level_mode), .irq_i(irq), .take_i(take), .irr_o(irr)
  );

  assign pend = irr & ~mask;

  irq_prio_pick #(.N_LVL(N_LVL)) pend_pick_i (
    .vec_i(pend), .any_o(pend_any), .lvl_o(pend_lvl)
  );

  irq_prio_pick #(.N_LVL(N_LVL)) isr_pick_i (
    .vec_i(isr_q), .any_o(isr_any), .lvl_o(isr_lvl)
  );

  assign int_out = init_done & pend_any & (~isr_any | (pend_lvl < isr_lvl));
  assign ack_go  = ack_stb & init_done;
  assign take    = (ack_go && step_q == 2'd0 && pend_any) ?
                   (N_LVL'(1) << pend_lvl) : '0;

  always_comb begin
    isr_d = isr_q | take;
    if (ack_go && step_q == 2'd1 && cfg.auto_eoi && cur_real_q)
      isr_d = isr_d & ~(N_LVL'(1) << cur_lvl_q);
    if (eoi_any && isr_any)
      isr_d = isr_d & ~(N_LVL'(1) << isr_lvl);
    if (eoi_spec)
      isr_d = isr_d & ~(N_LVL'(1) << eoi_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q      <= '0;
      step_q     <= 2'd0;
      cur_lvl_q  <= '0;
      cur_real_q <= 1'b0;
    end else if (restart) begin
      isr_q      <= '0;
      step_q     <= 2'd0;
      cur_real_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      if (ack_go) begin
        step_q <= (step_q == 2'd2) ? 2'd0 : step_q + 2'd1;
        if (step_q == 2'd0) begin
          cur_lvl_q  <= pend_any ? pend_lvl : LVL_W'(N_LVL - 1);
          cur_real_q <= pend_any;
        end
      end
    end
  end

  assign low_byte = cfg.four_byte ? {cfg.base_hi, cur_lvl_q, 2'b00}
                                  : {cfg.base_hi[2:1], cur_lvl_q, 3'b000};

  always_comb begin
    case (step_q)
      2'd0:    ack_byte = CALL_OPCODE;
      2'd1:    ack_byte = low_byte;
      default: ack_byte = cfg.page;
    endcase
  end

  always_comb begin
    if (cs && rd) rdata = a0 ? 8'(mask) : (read_isr ? 8'(isr_q) : 8'(irr));
    else          rdata = 8'h00;
  end
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
  parameter int N_LVL = 8,
  localparam int LVL_W = $clog2(N_LVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_done,
  input logic             int_out,
  input logic             restart,
  input logic             eoi,
  input logic             ack_go,
  input logic             pend_any,
  input logic             auto_eoi,
  input logic [1:0]       step,
  input logic [LVL_W-1:0] cur_lvl,
  input logic [N_LVL-1:0] irr,
  input logic [N_LVL-1:0] mask,
  input logic [N_LVL-1:0] isr
);
  // R3
  int_before_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !int_out);

  // R3
  int_after_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !int_out);

  // R4
  int_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != '0));

  // R5
  ack_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go && step == 2'd2 && !restart |=> step == 2'd0);

  // R6
  ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go && step == 2'd0 && pend_any && !eoi && !restart
    |=> $countones(isr) == $countones($past(isr)) + 1);

  // R8
  auto_eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go && step == 2'd1 && auto_eoi && !restart |=> !isr[$past(cur_lvl)]);

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (mask == '0) && (irr == '0) && (isr == '0));
endmodule

bind irq_vector_ctrl irq_vector_chk #(.N_LVL(N_LVL)) chk_i (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .int_out(int_out),
  .restart(restart), .eoi(eoi_any | eoi_spec), .ack_go(ack_go),
  .pend_any(pend_any), .auto_eoi(cfg.auto_eoi), .step(step_q),
  .cur_lvl(cur_lvl_q), .irr(irr), .mask(mask), .isr(isr_q)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, a0 = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq = 8'h00;
  logic       int_out;
  logic       ack_stb = 1'b0;
  logic [7:0] ack_byte;

  int tests_run = 0;
  int tests_failed = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .a0(a0),
    .wdata(wdata), .rdata(rdata), .irq(irq), .int_out(int_out),
    .ack_stb(ack_stb), .ack_byte(ack_byte)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic addr, input logic [7:0] d);
    @(posedge clk); #1;
    cs = 1'b1; wr = 1'b1; a0 = addr; wdata = d;
    @(posedge clk); #1;
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic addr, input logic [7:0] exp, input string req);
    @(posedge clk); #1;
    cs = 1'b1; rd = 1'b1; a0 = addr;
    @(negedge clk);
    chk(req, rdata, exp);
    @(posedge clk); #1;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic chk_int(input logic exp, input string req);
    @(negedge clk);
    chk(req, {7'd0, int_out}, {7'd0, exp});
  endtask

  // driver: queue the three expected bytes, then strobe three times
  task automatic ack_expect(input logic [7:0] lo, input logic [7:0] hi, input string req);
    exp_q.push_back(8'hCD); tag_q.push_back({req, " call"});
    exp_q.push_back(lo);    tag_q.push_back({req, " low"});
    exp_q.push_back(hi);    tag_q.push_back({req, " high"});
    repeat (3) begin
      @(posedge clk); #1; ack_stb = 1'b1;
      @(posedge clk); #1; ack_stb = 1'b0;
    end
  endtask

  // monitor: compare every acknowledge byte against the scoreboard
  always @(negedge clk) begin
    if (ack_stb) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected ack", ack_byte, 8'hxx);
      end else begin
        chk(tag_q.pop_front(), ack_byte, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk_int(1'b0, "R3 reset int low");
    rd_reg(1'b1, 8'h00, "R11 reset mask");
    irq = 8'h01;
    idle(3);
    chk_int(1'b0, "R3 no int before init");

    // edge mode, 4-byte spacing, base 011, page 20, options word normal eoi
    wr_reg(1'b0, 8'h77);
    wr_reg(1'b1, 8'h20);
    wr_reg(1'b1, 8'h00);
    idle(3);
    chk_int(1'b0, "R2 line high across init not taken");
    rd_reg(1'b0, 8'h00, "R2 pending empty after init");

    irq = 8'h00; idle(2);
    irq = 8'h24; idle(3);
    chk_int(1'b1, "R4 int for unmasked request");
    rd_reg(1'b0, 8'h24, "R12 pending read");
    ack_expect(8'h68, 8'h20, "R1 R7 level2 4-byte");
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, 8'h04, "R6 in-service set");
    wr_reg(1'b0, 8'h0A);
    rd_reg(1'b0, 8'h20, "R6 pending cleared for winner");
    chk_int(1'b0, "R4 lower level blocked by in-service");

    irq = 8'h25; idle(3);
    chk_int(1'b1, "R1 R4 level0 outranks in-service");
    ack_expect(8'h60, 8'h20, "R1 level0 vector");
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, 8'h05, "R8 in-service kept without auto eoi");
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, 8'h04, "R9 nonspecific eoi clears level0");
    chk_int(1'b0, "R4 still blocked by level2");
    wr_reg(1'b0, 8'h20);
    rd_reg(1'b0, 8'h00, "R9 nonspecific eoi clears level2");
    chk_int(1'b1, "R4 level5 now signalled");
    ack_expect(8'h74, 8'h20, "R7 level5 vector");
    rd_reg(1'b0, 8'h20, "R6 level5 in service");
    wr_reg(1'b0, 8'h65);
    rd_reg(1'b0, 8'h00, "R9 specific eoi level5");
    idle(2);
    chk_int(1'b0, "R2 held line does not retrigger");

    irq = 8'h00; idle(2);
    wr_reg(1'b1, 8'h08);
    rd_reg(1'b1, 8'h08, "R11 mask readback");
    irq = 8'h08; idle(3);
    chk_int(1'b0, "R11 masked line silent");
    wr_reg(1'b0, 8'h0A);
    rd_reg(1'b0, 8'h08, "R11 masked line latched");
    wr_reg(1'b1, 8'h00);
    chk_int(1'b1, "R11 unmask raises int");
    ack_expect(8'h6C, 8'h20, "R7 level3 vector");
    wr_reg(1'b0, 8'h20);

    // level mode, 8-byte spacing, base 101, page 44, auto eoi
    wr_reg(1'b1, 8'hF0);
    wr_reg(1'b0, 8'h0B);
    irq = 8'h40;
    wr_reg(1'b0, 8'hBB);
    rd_reg(1'b1, 8'h00, "R10 init clears mask");
    idle(1);
    rd_reg(1'b0, 8'h40, "R10 R12 read select back to pending");
    chk_int(1'b0, "R3 no int mid-init");
    wr_reg(1'b1, 8'h44);
    wr_reg(1'b1, 8'h02);
    idle(1);
    chk_int(1'b1, "R13 level request");
    ack_expect(8'hB0, 8'h44, "R7 R13 level6 8-byte");
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, 8'h00, "R8 auto eoi cleared in-service");
    chk_int(1'b1, "R13 level request again while high");
    irq = 8'h00; idle(3);
    chk_int(1'b0, "R13 request gone with low line");

    // no options word: auto eoi forced off
    wr_reg(1'b0, 8'hBA);
    wr_reg(1'b1, 8'h44);
    wr_reg(1'b0, 8'h0B);
    irq = 8'h02; idle(3);
    ack_expect(8'h88, 8'h44, "R5 level1 8-byte");
    rd_reg(1'b0, 8'h02, "R10 auto eoi off without options word");
    wr_reg(1'b0, 8'h20);
    irq = 8'h00; idle(3);
    chk_int(1'b0, "R4 idle after eoi");
    ack_expect(8'hB8, 8'h44, "R6 nothing pending gives level7");
    rd_reg(1'b0, 8'h00, "R6 in-service unchanged on empty ack");

    idle(2);
    chk("R5 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule